// File: doc/BRIEF.md
# Descriptor Ring Bus-Master Engine

This block is a bus-master DMA engine that walks a circular table of transfer descriptors stored in system memory. Each descriptor occupies 16 bytes and tells the engine where to read data from, which destination offset to tag it with, how many bytes to move and whether it is the final entry of the list. The engine reads the data as 32-bit words over a simple request/response memory port and hands every word, paired with its destination offset, to a downstream command port through a valid/ready handshake.

Software arms the engine with a single configuration strobe that carries a table address and a 2-bit ring-size code. It tracks progress by reading a busy flag and a table pointer. While the engine runs, the pointer already names the descriptor after the one being worked on, so software reads the busy flag first and subtracts one descriptor when it is set. The pointer advances modulo the ring size, inside the aligned block that holds the table. After a final-entry descriptor, or at a descriptor boundary while the bus-master disable input is high, the engine goes idle and waits for a new start strobe.

Top module: `ring_bm_engine`

## Requirements
- R1: After reset the engine is idle: `stat_busy` = 0, `stat_ptr` = 0, `mem_req` = 0 and `out_valid` = 0.
- R2: `cfg_wr` while idle with `bm_dis` low starts the engine at `cfg_base` with bits [3:0] cleared. Each descriptor is fetched as three reads, in order: +0 (destination offset), +4 (source address) and +8 (command word). The word at +12 is never read. `mem_addr` is held stable while `mem_req` waits for `mem_rvalid`.
- R3: Command bits [12:0] give the byte count. Counts above 4096 are treated as 4096, and the count is rounded down to whole words. Word i is read from source + 4*i and presented with `out_data` equal to that word and `out_addr` equal to destination + 4*i.
- R4: When command bit 30 is set, every word of the descriptor carries the unchanged destination offset.
- R5: A descriptor whose word count is zero issues no data read and produces no output word.
- R6: After finishing a descriptor with command bit 31 set, the engine goes idle. `stat_ptr` then holds the address of the following descriptor, and nothing more is fetched until the next `cfg_wr`.
- R7: A descriptor with bit 31 clear is followed by the descriptor 16 bytes further on.
- R8: While busy, `stat_ptr` is the address of the descriptor in progress plus 16, after ring wrap. `stat_ptr[3:0]` is always zero.
- R9: The ring span is 16 KB shifted left by the ring code (0 = 16 KB, 1 = 32 KB, 2 = 64 KB, 3 = 128 KB). The table pointer steps by 16 within the span-aligned block and wraps to its base.
- R10: With `bm_dis` high, the engine goes idle at the next descriptor boundary, and a `cfg_wr` that arrives while idle is ignored.
- R11: A `cfg_wr` that arrives while busy is ignored.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Start strobe: load table address and ring code |
| cfg_base | input | 32 | Table start address (low 4 bits ignored) |
| cfg_ring_code | input | 2 | Ring span code |
| bm_dis | input | 1 | Bus-master disable: stop at next descriptor boundary |
| stat_busy | output | 1 | Engine active |
| stat_ptr | output | 32 | Table pointer, descriptor aligned |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read response data |
| out_valid | output | 1 | Downstream word valid |
| out_addr | output | 32 | Destination offset of the word |
| out_data | output | 32 | Data word |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Single-descriptor lists are run with the following command words: a plain count, a held destination, a zero count, exactly 4096 bytes, an oversized count, a count that is not a multiple of 4, and stray middle bits. Together they separate the count decoding from the clamp and the hold flag. Each start address is chosen for one purpose: one is unaligned, one sits at the last slot of a 16 KB ring, and the same slot is also used under a 32 KB ring, so wrap and non-wrap of the pointer are told apart. A three-entry chain is run under output back-pressure to show chaining, the look-ahead pointer, the stop at the final-entry flag and that a mid-run start strobe has no effect. A separate run raises the disable input during the first descriptor.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int ADDR_W         = 32;
  localparam int DATA_W         = 32;
  localparam int DESC_BYTES     = 16;
  localparam int MAX_XFER_BYTES = 4096;
  localparam int CNT_W          = $clog2(MAX_XFER_BYTES) + 1;
  localparam int WCNT_W         = CNT_W - 2;
  localparam int RING_CODE_W    = 2;
  localparam int MIN_RING_LOG   = 14;
  localparam int LAST_BIT       = 31;
  localparam int HOLD_BIT       = 30;
  localparam int WIDX_W         = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_READ,
    S_SEND,
    S_NEXT
  } bm_state_e;

  // byte count field -> whole words, clamped to the per-descriptor maximum
  function automatic logic [WCNT_W-1:0] words_of(input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] c;
    c = (cnt > CNT_W'(MAX_XFER_BYTES)) ? CNT_W'(MAX_XFER_BYTES) : cnt;
    return WCNT_W'(c >> 2);
  endfunction

  // advance one descriptor inside the span-aligned ring block
  function automatic logic [ADDR_W-1:0] ring_step(input logic [ADDR_W-1:0] p,
                                                  input logic [RING_CODE_W-1:0] code);
    logic [ADDR_W-1:0] span_mask;
    span_mask = (ADDR_W'(1) << (MIN_RING_LOG + int'(code))) - ADDR_W'(1);
    return (p & ~span_mask) | ((p + ADDR_W'(DESC_BYTES)) & span_mask);
  endfunction
endpackage

// File: rtl/rbm_tbl_ptr.sv
module rbm_tbl_ptr
  import rbm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [ADDR_W-1:0]      load_base,
  input  logic [RING_CODE_W-1:0] load_code,
  input  logic                   adv_en,
  output logic [ADDR_W-1:0]      cur_ptr,
  output logic [ADDR_W-1:0]      tbl_ptr
);
  logic [ADDR_W-1:0]      cur_q, cur_d, tbl_q, tbl_d, base_al;
  logic [RING_CODE_W-1:0] code_q, code_d;
  logic                   upd_en;

  assign base_al = load_base & ~ADDR_W'(DESC_BYTES - 1);
  assign upd_en  = load_en | adv_en;

  always_comb begin
    cur_d  = cur_q;
    tbl_d  = tbl_q;
    code_d = code_q;
    if (load_en) begin
      cur_d  = base_al;
      tbl_d  = ring_step(base_al, load_code);
      code_d = load_code;
    end else if (adv_en) begin
      cur_d  = tbl_q;
      tbl_d  = ring_step(tbl_q, code_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      tbl_q  <= '0;
      code_q <= '0;
    end else if (upd_en) begin
      cur_q  <= cur_d;
      tbl_q  <= tbl_d;
      code_q <= code_d;
    end
  end

  assign cur_ptr = cur_q;
  assign tbl_ptr = tbl_q;
endmodule

// File: rtl/rbm_desc_latch.sv
module rbm_desc_latch
  import rbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WIDX_W-1:0] cap_idx,
  input  logic [DATA_W-1:0] cap_word,
  output logic [ADDR_W-1:0] d_dst,
  output logic [ADDR_W-1:0] d_src,
  output logic              d_last,
  output logic              d_hold,
  output logic [WCNT_W-1:0] d_nwords
);
  logic [ADDR_W-1:0] dst_q, src_q;
  logic              last_q, hold_q;
  logic [WCNT_W-1:0] nw_q;
  logic              en_dst, en_src, en_cmd;

  assign en_dst = cap_en && (cap_idx == WIDX_W'(0));
  assign en_src = cap_en && (cap_idx == WIDX_W'(1));
  assign en_cmd = cap_en && (cap_idx == WIDX_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst_q <= '0;
    else if (en_dst) dst_q <= cap_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else if (en_src) src_q <= cap_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      hold_q <= 1'b0;
      nw_q   <= '0;
    end else if (en_cmd) begin
      last_q <= cap_word[LAST_BIT];
      hold_q <= cap_word[HOLD_BIT];
      nw_q   <= words_of(cap_word[CNT_W-1:0]);
    end
  end

  assign d_dst    = dst_q;
  assign d_src    = src_q;
  assign d_last   = last_q;
  assign d_hold   = hold_q;
  assign d_nwords = nw_q;
endmodule

// File: rtl/rbm_beat_ctr.sv
module rbm_beat_ctr
  import rbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [WCNT_W-1:0] nwords,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              hold,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last
);
  logic [WCNT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    beat_d = beat_q;
    if (clr)      beat_d = '0;
    else if (inc) beat_d = beat_q + WCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (clr || inc) beat_q <= beat_d;
  end

  assign offs     = ADDR_W'({beat_q, 2'b00});
  assign src_addr = src + offs;
  assign dst_addr = hold ? dst : (dst + offs);
  assign last     = (beat_q == (nwords - WCNT_W'(1)));
endmodule

// File: rtl/ring_bm_engine.sv
module ring_bm_engine
  import rbm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [RING_CODE_W-1:0] cfg_ring_code,
  input  logic                   bm_dis,
  output logic                   stat_busy,
  output logic [ADDR_W-1:0]      stat_ptr,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_rvalid,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   out_valid,
  output logic [ADDR_W-1:0]      out_addr,
  output logic [DATA_W-1:0]      out_data,
  input  logic                   out_ready
);
  bm_state_e         state_q, state_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] cur_ptr, tbl_ptr, d_dst, d_src, beat_src, beat_dst;
  logic              d_last, d_hold, beat_last;
  logic [WCNT_W-1:0] d_nwords, new_words;
  logic              start, fetch_hit, fetch_done, read_hit, send_fire, adv;
  logic              beat_clr, beat_inc, widx_en;

  assign start      = (state_q == S_IDLE) && cfg_wr && !bm_dis;
  assign fetch_hit  = (state_q == S_FETCH) && mem_rvalid;
  assign fetch_done = fetch_hit && (widx_q == WIDX_W'(2));
  assign read_hit   = (state_q == S_READ) && mem_rvalid;
  assign send_fire  = (state_q == S_SEND) && out_ready;
  assign adv        = (state_q == S_NEXT) && !d_last && !bm_dis;
  assign beat_clr   = fetch_done || (send_fire && beat_last);
  assign beat_inc   = send_fire && !beat_last;
  assign new_words  = words_of(mem_rdata[CNT_W-1:0]);
  assign widx_en    = start || adv || fetch_hit;

  rbm_tbl_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (start),
    .load_base (cfg_base),
    .load_code (cfg_ring_code),
    .adv_en    (adv),
    .cur_ptr   (cur_ptr),
    .tbl_ptr   (tbl_ptr)
  );

  rbm_desc_latch u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (fetch_hit),
    .cap_idx  (widx_q),
    .cap_word (mem_rdata),
    .d_dst    (d_dst),
    .d_src    (d_src),
    .d_last   (d_last),
    .d_hold   (d_hold),
    .d_nwords (d_nwords)
  );

  rbm_beat_ctr u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (beat_clr),
    .inc      (beat_inc),
    .nwords   (d_nwords),
    .src      (d_src),
    .dst      (d_dst),
    .hold     (d_hold),
    .src_addr (beat_src),
    .dst_addr (beat_dst),
    .last     (beat_last)
  );

  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    case (state_q)
      S_IDLE:  if (start) state_d = S_FETCH;
      S_FETCH: if (fetch_done) state_d = (new_words == '0) ? S_NEXT : S_READ;
      S_READ:  if (read_hit) state_d = S_SEND;
      S_SEND:  if (send_fire) state_d = beat_last ? S_NEXT : S_READ;
      S_NEXT:  state_d = (d_last || bm_dis) ? S_IDLE : S_FETCH;
      default: state_d = S_IDLE;
    endcase
    if (start || adv)   widx_d = '0;
    else if (fetch_hit) widx_d = widx_q + WIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) widx_q <= '0;
    else if (widx_en) widx_q <= widx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (read_hit) data_q <= mem_rdata;
  end

  assign stat_busy = (state_q != S_IDLE);
  assign stat_ptr  = tbl_ptr;
  assign mem_req   = (state_q == S_FETCH) || (state_q == S_READ);
  assign mem_addr  = (state_q == S_FETCH) ? (cur_ptr + ADDR_W'({widx_q, 2'b00})) : beat_src;
  assign out_valid = (state_q == S_SEND);
  assign out_addr  = beat_dst;
  assign out_data  = data_q;
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker
  import rbm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              bm_dis,
  input logic              stat_busy,
  input logic [ADDR_W-1:0] stat_ptr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data
);
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ptr[3:0] == 4'd0); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr)); // R12

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy |-> !mem_req && !out_valid); // R6

  AST_IDLE_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy && !cfg_wr |=> $stable(stat_ptr)); // R6

  AST_DIS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy && bm_dis |=> !stat_busy); // R10

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && out_valid)); // R3
endmodule

bind ring_bm_engine rbm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .bm_dis     (bm_dis),
  .stat_busy  (stat_busy),
  .stat_ptr   (stat_ptr),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_data   (out_data)
);

// File: tb/sim_ring_bm_engine.sv
`timescale 1ns/1ps
module sim_ring_bm_engine;
  localparam logic [31:0] PAT     = 32'hC3C3_0000;
  localparam logic [31:0] TB_BASE = 32'h0001_0000;
  localparam int          TB_WORDS = 8192;
  localparam int          NVEC = 8;
  // base, ring code, dst, src, cmd
  localparam logic [31:0] VEC [0:NVEC-1][0:4] = '{
    '{32'h0001_0000, 32'd0, 32'h0000_0100, 32'h0020_0000, 32'h8000_0010},
    '{32'h0001_0040, 32'd0, 32'h0000_0200, 32'h0030_0004, 32'hC000_000C},
    '{32'h0001_0080, 32'd0, 32'h0000_0300, 32'h0040_0000, 32'h8000_0000},
    '{32'h0001_00C0, 32'd0, 32'h0000_1000, 32'h0050_0000, 32'h8000_1000},
    '{32'h0001_0100, 32'd0, 32'h0000_2000, 32'h0060_0000, 32'h8000_1FFC},
    '{32'h0001_3FF0, 32'd0, 32'h0000_0400, 32'h0070_0000, 32'h8000_0008},
    '{32'h0001_3FF0, 32'd1, 32'h0000_0500, 32'h0080_0000, 32'h8000_0008},
    '{32'h0001_0145, 32'd0, 32'h0000_0600, 32'h0090_0000, 32'h8123_400A}
  };

  logic        clk, rst_n, cfg_wr, bm_dis, stat_busy, mem_req, mem_rvalid;
  logic        out_valid, out_ready;
  logic [1:0]  cfg_ring_code;
  logic [31:0] cfg_base, stat_ptr, mem_addr, mem_rdata, out_addr, out_data;

  logic [31:0] tmem [0:TB_WORDS-1];
  logic [31:0] cap_addr [0:4095];
  logic [31:0] cap_data [0:4095];
  int cap_n, data_reads, tbl_reads, n_chk, n_bad, rcyc;
  bit stall;

  ring_bm_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
    .cfg_ring_code(cfg_ring_code), .bm_dis(bm_dis), .stat_busy(stat_busy),
    .stat_ptr(stat_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .out_ready(out_ready)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic in_tbl(input logic [31:0] a);
    return (a >= TB_BASE) && (a < TB_BASE + 32'(TB_WORDS * 4));
  endfunction

  function automatic int exp_words(input logic [31:0] cmd);
    int c;
    c = int'(cmd & 32'h1FFF);
    if (c > 4096) c = 4096;
    return c / 4;
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic [1:0] code);
    logic [31:0] span;
    span = 32'h4000 << code;
    return (p & ~(span - 1)) | ((p + 32'd16) & (span - 1));
  endfunction

  // memory model: one response a cycle after each request
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    data_reads = 0;
    tbl_reads  = 0;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_rvalid) begin
        mem_rvalid <= 1'b1;
        if (in_tbl(mem_addr)) begin
          mem_rdata <= tmem[(mem_addr - TB_BASE) >> 2];
          tbl_reads++;
        end else begin
          mem_rdata <= mem_addr ^ PAT;
          data_reads++;
        end
      end else begin
        mem_rvalid <= 1'b0;
      end
    end
  end

  // downstream: ready pattern and word capture
  initial begin
    out_ready = 1'b1;
    rcyc = 0;
    cap_n = 0;
    forever begin
      @(negedge clk);
      rcyc++;
      out_ready = stall ? ((rcyc % 3) != 0) : 1'b1;
      #1;
      if (out_valid && out_ready && cap_n < 4096) begin
        cap_addr[cap_n] = out_addr;
        cap_data[cap_n] = out_data;
        cap_n++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] dst,
                          input logic [31:0] src, input logic [31:0] cmd);
    int i;
    i = int'((a - TB_BASE) >> 2);
    tmem[i]     = dst;
    tmem[i + 1] = src;
    tmem[i + 2] = cmd;
    tmem[i + 3] = 32'hDEAD_0000;
  endtask

  task automatic kick(input logic [31:0] b, input logic [1:0] c);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_base = b;
    cfg_ring_code = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #2;
      if (!stat_busy) break;
    end
  endtask

  task automatic cmp_desc(input string tag, input int first, input logic [31:0] dst,
                          input logic [31:0] src, input logic [31:0] cmd);
    int bad;
    logic [31:0] ea, ed;
    bad = 0;
    for (int i = 0; i < exp_words(cmd); i++) begin
      ea = cmd[30] ? dst : dst + 32'(4 * i);
      ed = (src + 32'(4 * i)) ^ PAT;
      if (cap_addr[first + i] !== ea || cap_data[first + i] !== ed) bad++;
    end
    chk(tag, 32'(bad), 32'd0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] al, saved_a, saved_d, p0;
    int d0, t0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_base = '0; cfg_ring_code = '0;
    bm_dis = 1'b0; stall = 1'b0;
    for (int i = 0; i < TB_WORDS; i++) tmem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 busy", 32'(stat_busy), 32'd0);
    chk("R1 ptr", stat_ptr, 32'd0);
    chk("R1 req", 32'(mem_req), 32'd0);
    chk("R1 valid", 32'(out_valid), 32'd0);

    // table-driven single-descriptor runs
    for (int v = 0; v < NVEC; v++) begin
      al = VEC[v][0] & ~32'hF;
      put_desc(al, VEC[v][2], VEC[v][3], VEC[v][4]);
      cap_n = 0; d0 = data_reads; t0 = tbl_reads;
      kick(VEC[v][0], VEC[v][1][1:0]);
      wait_idle();
      chk("R3 R4 word count", 32'(cap_n), 32'(exp_words(VEC[v][4])));
      cmp_desc("R3 R4 words", 0, VEC[v][2], VEC[v][3], VEC[v][4]);
      chk("R5 data reads", 32'(data_reads - d0), 32'(exp_words(VEC[v][4])));
      chk("R2 table reads", 32'(tbl_reads - t0), 32'd3);
      chk("R6 R9 pointer", stat_ptr, exp_next(al, VEC[v][1][1:0]));
    end

    // chain under back-pressure, start strobe while busy
    put_desc(32'h0001_0200, 32'h700, 32'h00A0_0000, 32'h0000_0008);
    put_desc(32'h0001_0210, 32'h800, 32'h00B0_0000, 32'h4000_0004);
    put_desc(32'h0001_0220, 32'h900, 32'h00C0_0000, 32'h8000_0008);
    put_desc(32'h0001_0230, 32'hA00, 32'h00D0_0000, 32'h8000_0004);
    stall = 1'b1; cap_n = 0; d0 = data_reads;
    kick(32'h0001_0200, 2'd0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #2;
      if (out_valid) break;
    end
    chk("R8 busy pointer", stat_ptr, 32'h0001_0210);
    chk("R8 busy flag", 32'(stat_busy), 32'd1);
    kick(32'h0001_0400, 2'd0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #2;
      if (out_valid && !out_ready) break;
    end
    saved_a = out_addr; saved_d = out_data;
    @(negedge clk); #2;
    chk("R12 held addr", out_addr, saved_a);
    chk("R12 held data", out_data, saved_d);
    wait_idle();
    stall = 1'b0;
    chk("R7 R6 chain words", 32'(cap_n), 32'd5);
    cmp_desc("R7 first", 0, 32'h700, 32'h00A0_0000, 32'h0000_0008);
    cmp_desc("R4 R7 second", 2, 32'h800, 32'h00B0_0000, 32'h4000_0004);
    cmp_desc("R7 third", 3, 32'h900, 32'h00C0_0000, 32'h8000_0008);
    chk("R11 R6 pointer", stat_ptr, 32'h0001_0230);
    chk("R11 data reads", 32'(data_reads - d0), 32'd5);

    // restart from the halted pointer picks up the next entry
    cap_n = 0;
    kick(stat_ptr, 2'd0);
    wait_idle();
    chk("R6 restart words", 32'(cap_n), 32'd1);
    cmp_desc("R6 restart data", 0, 32'hA00, 32'h00D0_0000, 32'h8000_0004);
    chk("R6 restart pointer", stat_ptr, 32'h0001_0240);

    // disable stops at the first boundary; start ignored while disabled
    put_desc(32'h0001_0300, 32'hB00, 32'h00E0_0000, 32'h0000_0010);
    put_desc(32'h0001_0310, 32'hC00, 32'h00F0_0000, 32'h0000_0010);
    put_desc(32'h0001_0320, 32'hD00, 32'h0100_0000, 32'h8000_0010);
    cap_n = 0;
    kick(32'h0001_0300, 2'd0);
    bm_dis = 1'b1;
    wait_idle();
    chk("R10 words before stop", 32'(cap_n), 32'd4);
    chk("R10 stop pointer", stat_ptr, 32'h0001_0310);
    p0 = stat_ptr; cap_n = 0;
    kick(32'h0001_0320, 2'd0);
    repeat (20) @(negedge clk);
    #2;
    chk("R10 ignored start busy", 32'(stat_busy), 32'd0);
    chk("R10 ignored start ptr", stat_ptr, p0);
    chk("R10 ignored start words", 32'(cap_n), 32'd0);
    bm_dis = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule